// File: doc/BRIEF.md
# Programmable PC Card Strobe Sequencer

This block runs one 8-bit memory or I/O access to a PC Card. Each access has three timed phases. In the first, the address and enables are set up. In the second, one command strobe is held low. In the third, the address and enables are held while the strobe is released. Each phase lasts its programmed value plus one clock periods.

The three phase lengths come from one of two timer sets, and the requester picks the set per access. Six 8-bit timer registers are written through a small index/data port. A requester starts an access by presenting the following on a single cycle while the block is idle:

- the address,
- the direction,
- a memory/I/O flag,
- a register-space flag,
- an odd-byte flag,
- an upper-lane choice,
- the write data,
- the timer-set select.

The block steers the byte onto the lower or upper data lane and asserts only the matching card enable. For reads, it captures the returned byte as the strobe ends. It reports completion with a single-cycle pulse.

Top module: `pccard_strobe_seq`

## Requirements
- R1: After an accepted request, the setup phase lasts S = setup value + 1 clocks. During it the card enable and address are driven and all four command strobes are high.
- R2: The command phase lasts C = command value + 1 clocks. Exactly one strobe is low during it: `card_oe_n` for a memory read, `card_we_n` for a memory write, `card_iord_n` for an I/O read, `card_iowr_n` for an I/O write.
- R3: The recovery phase lasts R = recovery value + 1 clocks, with all strobes high. The address, enable and register-select outputs are held unchanged until it ends.
- R4: Timer register index = 3 × set + phase, where phase 0 is setup, 1 is command and 2 is recovery. Indices 6 and 7 are ignored. `req_tset` chooses the set an access uses.
- R5: After reset, set 0 holds setup 0, command 7 and recovery 4, so an access lasts 1, 8 and 5 clocks. Set 1 holds all zeros, giving 1, 1 and 1 clocks.
- R6: The card enable follows the requested lane. An even access (`req_odd`=0, `req_hi_lane` ignored) drives `card_ce1_n` low. An odd access with `req_hi_lane`=0 also drives `card_ce1_n` low. An odd access with `req_hi_lane`=1 drives `card_ce2_n` low and `card_ce1_n` high. Both enables are high when idle.
- R7: A read captures the active lane (bits 7:0 for the lower lane, 15:8 for the upper lane) into `rd_data` on the clock edge that ends the command phase. `card_d_oe` stays 0 for the whole read.
- R8: A write drives `req_wdata` on the active lane from the first setup clock to the last recovery clock. The drive enable for that lane is raised: bit 0 for the lower lane, bit 1 for the upper lane. `card_d_oe` is 0 otherwise.
- R9: `card_reg_n` is low for the whole access when `req_regspace` is 1, and high otherwise and when idle.
- R10: `busy` is high from the clock after acceptance until recovery ends. A request presented while busy is ignored.
- R11: `done` is high for exactly one clock: the first idle clock after recovery.
- R12: A timer write made during an access does not change that access. It applies from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timer register write strobe |
| cfg_idx | input | 3 | Timer register index |
| cfg_wdata | input | TW | Timer register write value |
| req_valid | input | 1 | Start request, taken when idle |
| req_addr | input | AW | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_regspace | input | 1 | Register (attribute) space select |
| req_odd | input | 1 | Odd-byte access |
| req_hi_lane | input | 1 | Odd byte uses upper lane |
| req_wdata | input | 8 | Write byte |
| req_tset | input | 1 | Timer set select |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Captured read byte |
| card_addr | output | AW | Card address |
| card_reg_n | output | 1 | Register-space select, active low |
| card_ce1_n | output | 1 | Lower-lane card enable, active low |
| card_ce2_n | output | 1 | Upper-lane card enable, active low |
| card_oe_n | output | 1 | Memory read strobe, active low |
| card_we_n | output | 1 | Memory write strobe, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |
| card_d_out | output | 16 | Data bus drive value |
| card_d_oe | output | 2 | Per-lane drive enables |
| card_d_in | input | 16 | Data bus input |

## Verification
A wrong phase counter or a wrong state shows at once as a setup, strobe or recovery period that is one or more clocks off from its programmed length. The bench counts these periods at the ports on every access. A wrong latched lane or direction shows in the same cycle as the wrong enable, wrong strobe or wrong drive enable. A wrong capture edge shows in `rd_data` as soon as `done` pulses, because the bench drives the bus to a different value outside the command phase. A request leaking in while busy shows as an address change mid-access, or as a second access after `done`.

// File: rtl/pccard_strobe_seq.sv
module pccard_strobe_seq #(
  parameter int AW = 26,
  parameter int TW = 8,
  parameter int S0_SETUP = 0,
  parameter int S0_CMD = 7,
  parameter int S0_REC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_regspace,
  input  logic          req_odd,
  input  logic          req_hi_lane,
  input  logic [7:0]    req_wdata,
  input  logic          req_tset,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rd_data,
  output logic [AW-1:0] card_addr,
  output logic          card_reg_n,
  output logic          card_ce1_n,
  output logic          card_ce2_n,
  output logic          card_oe_n,
  output logic          card_we_n,
  output logic          card_iord_n,
  output logic          card_iowr_n,
  output logic [15:0]   card_d_out,
  output logic [1:0]    card_d_oe,
  input  logic [15:0]   card_d_in
);
  localparam int NREG = 6;

  typedef enum logic [1:0] {IDLE, SETUP, CMD, REC} st_t;

  st_t           st;
  logic [TW-1:0] tmr [NREG];
  logic [TW-1:0] cnt, cmd_q, rec_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdat_q, rd_q;
  logic          wr_q, io_q, reg_q, hi_q, done_q;
  logic [2:0]    base;

  wire act    = (st != IDLE);
  wire strb   = (st == CMD);
  wire accept = req_valid && (st == IDLE);

  assign base = req_tset ? 3'd3 : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr[0] <= TW'(S0_SETUP);
      tmr[1] <= TW'(S0_CMD);
      tmr[2] <= TW'(S0_REC);
      for (int i = 3; i < NREG; i++) tmr[i] <= '0;
    end else if (cfg_we && (cfg_idx < 3'(NREG))) begin
      tmr[cfg_idx] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      cmd_q  <= '0;
      rec_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      rd_q   <= '0;
      wr_q   <= 1'b0;
      io_q   <= 1'b0;
      reg_q  <= 1'b0;
      hi_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          st     <= SETUP;
          cnt    <= tmr[base];
          cmd_q  <= tmr[base + 3'd1];
          rec_q  <= tmr[base + 3'd2];
          addr_q <= req_addr;
          wdat_q <= req_wdata;
          wr_q   <= req_write;
          io_q   <= req_io;
          reg_q  <= req_regspace;
          hi_q   <= req_odd & req_hi_lane;
        end
        SETUP: if (cnt == '0) begin
          st  <= CMD;
          cnt <= cmd_q;
        end else cnt <= cnt - 1'b1;
        CMD: if (cnt == '0) begin
          st  <= REC;
          cnt <= rec_q;
          if (!wr_q) rd_q <= hi_q ? card_d_in[15:8] : card_d_in[7:0];
        end else cnt <= cnt - 1'b1;
        REC: if (cnt == '0) begin
          st     <= IDLE;
          done_q <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assign busy        = act;
  assign done        = done_q;
  assign rd_data     = rd_q;
  assign card_addr   = addr_q;
  assign card_reg_n  = ~(act & reg_q);
  assign card_ce1_n  = ~(act & ~hi_q);
  assign card_ce2_n  = ~(act & hi_q);
  assign card_oe_n   = ~(strb & ~io_q & ~wr_q);
  assign card_we_n   = ~(strb & ~io_q & wr_q);
  assign card_iord_n = ~(strb & io_q & ~wr_q);
  assign card_iowr_n = ~(strb & io_q & wr_q);
  assign card_d_out  = {wdat_q, wdat_q};
  assign card_d_oe   = {act & wr_q & hi_q, act & wr_q & ~hi_q};

  wire strb_low = ~(card_oe_n & card_we_n & card_iord_n & card_iowr_n);

  a_r2_strobe_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    strb_low |-> $past(busy));
  a_r3_recovery_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_low && $past(strb_low)) |-> busy);
  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(card_addr));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r8_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((|card_d_oe) && $past(|card_d_oe)) |-> $stable(card_d_out));
endmodule

// File: tb/test_pccard_strobe_seq.sv
`timescale 1ns/1ps
module test_pccard_strobe_seq;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_idx = 0; logic [7:0] cfg_wdata = 0;
  logic req_valid = 0; logic [25:0] req_addr = 0;
  logic req_write = 0, req_io = 0, req_regspace = 0, req_odd = 0, req_hi_lane = 0, req_tset = 0;
  logic [7:0] req_wdata = 0;
  logic busy, done; logic [7:0] rd_data; logic [25:0] card_addr;
  logic card_reg_n, card_ce1_n, card_ce2_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n;
  logic [15:0] card_d_out, card_d_in = 0; logic [1:0] card_d_oe;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pccard_strobe_seq i_pccard_strobe_seq (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic check_idle(input string tag);
    chk(card_ce1_n && card_ce2_n, {tag, " R6 enables idle"}, {card_ce1_n, card_ce2_n}, 3);
    chk(card_d_oe == 0, {tag, " R8 no drive idle"}, card_d_oe, 0);
    chk(card_reg_n, {tag, " R9 reg high idle"}, card_reg_n, 1);
    chk({card_oe_n, card_we_n, card_iord_n, card_iowr_n} == 4'hF, {tag, " R2 strobes idle"},
        {card_oe_n, card_we_n, card_iord_n, card_iowr_n}, 15);
  endtask

  // lane: 0 even, 1 odd lower, 2 odd upper
  task automatic access(input bit wr, input bit io, input int lane, input bit hi_dontcare,
                        input bit regsp, input bit ts, input logic [25:0] addr, input logic [7:0] wd,
                        input int es, input int ec, input int er,
                        input bit poke, input bit midcfg, input int mid_idx, input int mid_val);
    int ns, nc, nr, cyc;
    bit bad_strb, bad_ce, bad_reg, bad_addr, bad_drv;
    logic [15:0] good;
    logic [3:0] lowv, expv;
    bit upper;
    upper = (lane == 2);
    good = {~wd, wd ^ 8'h5A} ^ addr[15:0];
    expv = 4'b0001 << (2 * io + wr);
    ns = 0; nc = 0; nr = 0; cyc = 0;
    bad_strb = 0; bad_ce = 0; bad_reg = 0; bad_addr = 0; bad_drv = 0;
    @(negedge clk);
    req_valid = 1; req_addr = addr; req_write = wr; req_io = io; req_regspace = regsp;
    req_odd = (lane != 0); req_hi_lane = (lane == 0) ? hi_dontcare : upper;
    req_wdata = wd; req_tset = ts; card_d_in = ~good;
    @(negedge clk);
    req_valid = 0;
    while (busy && cyc < 200) begin
      lowv = ~{card_iowr_n, card_iord_n, card_we_n, card_oe_n};
      if (lowv != 0) begin
        nc++;
        if (lowv != expv) bad_strb = 1;
      end else if (nc == 0) ns++;
      else nr++;
      if (card_ce1_n != upper || card_ce2_n != !upper) bad_ce = 1;
      if (card_reg_n != !regsp) bad_reg = 1;
      if (card_addr != addr) bad_addr = 1;
      if (wr) begin
        if (card_d_oe != (upper ? 2'b10 : 2'b01)) bad_drv = 1;
        if ((upper ? card_d_out[15:8] : card_d_out[7:0]) != wd) bad_drv = 1;
      end else if (card_d_oe != 0) bad_drv = 1;
      if (!wr) card_d_in = (lowv != 0) ? good : ~good;
      req_valid = (poke && cyc == 0);
      if (poke && cyc == 0) begin req_addr = ~addr; req_tset = ~ts; end
      cfg_we = (midcfg && cyc == 0);
      if (midcfg && cyc == 0) begin cfg_idx = 3'(mid_idx); cfg_wdata = 8'(mid_val); end
      cyc++;
      @(negedge clk);
    end
    req_valid = 0; cfg_we = 0;
    chk(done == 1, "R11 done in first idle cycle", done, 1);
    chk(ns == es, "R1 setup length", ns, es);
    chk(nc == ec, "R2 command length", nc, ec);
    chk(nr == er, "R3 recovery length", nr, er);
    chk(!bad_strb, "R2 strobe select", lowv, expv);
    chk(!bad_ce, "R6 card enable lane", upper, upper);
    chk(!bad_reg, "R9 register select", regsp, regsp);
    chk(!bad_addr, "R3 address held", card_addr, addr);
    chk(!bad_drv, "R7 R8 data drive", card_d_oe, wr ? (upper ? 2 : 1) : 0);
    if (!wr) chk(rd_data == (upper ? good[15:8] : good[7:0]), "R7 read capture", rd_data,
                 upper ? good[15:8] : good[7:0]);
    check_idle("post");
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
    chk(!busy, "R10 request while busy ignored", busy, 0);
  endtask

  initial begin
    #(5.0 * 199000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R10 reset busy/done", {busy, done}, 0);
    check_idle("reset");
    rst_n = 1;
    // R5 defaults
    access(0, 0, 0, 0, 0, 0, 26'h123, 8'h11, 1, 8, 5, 0, 0, 0, 0);
    access(1, 1, 2, 0, 1, 1, 26'h3FF0001, 8'h22, 1, 1, 1, 0, 0, 0, 0);
    // R4 indices 6 and 7 ignored
    cfg_write(6, 255); cfg_write(7, 255);
    access(1, 0, 1, 0, 0, 0, 26'h456, 8'h33, 1, 8, 5, 0, 0, 0, 0);
    access(0, 1, 0, 1, 0, 1, 26'h789, 8'h44, 1, 1, 1, 0, 0, 0, 0);
    // R4/R1/R2/R3/R6-R9 sweep
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) begin
          cfg_write(0, s); cfg_write(1, c); cfg_write(2, r);
          cfg_write(3, 3 - s); cfg_write(4, 3 - c); cfg_write(5, 3 - r);
          for (int m = 0; m < 12; m++) begin
            bit ts;
            ts = bit'((m + s) % 2);
            access(m[0], m[1], m / 4, bit'(c % 2), m[1] ^ r[0], ts,
                   26'((s << 20) | (c << 14) | (r << 8) | (m << 3) | 5), 8'(m * 17 + s * 5 + r),
                   ts ? 4 - s : s + 1, ts ? 4 - c : c + 1, ts ? 4 - r : r + 1, 0, 0, 0, 0);
          end
        end
    // R12 mid-access timer write, R10 request while busy
    cfg_write(0, 0); cfg_write(1, 2); cfg_write(2, 0);
    access(0, 0, 0, 0, 0, 0, 26'h2AA, 8'h55, 1, 3, 1, 1, 1, 1, 5);
    access(1, 1, 2, 0, 1, 0, 26'h155, 8'hAA, 1, 6, 1, 1, 1, 2, 3);
    access(0, 1, 1, 0, 0, 0, 26'h0F0, 8'h99, 1, 6, 4, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule